// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This is the purely combinational control block of a five-stage, in-order, 32-bit pipeline. The stages run fetch, decode, execute, memory, writeback. Each cycle it reads the register numbers, write enables and load flags of the instructions in the decode, execute, memory and writeback stages. From these it selects where each operand should take its value from, and it decides whether the front of the pipeline must hold or be cleared.

Branches resolve in decode, so the unit does two jobs. It steers the two execute-stage ALU operands. It also steers the two decode-stage comparator operands. The unit stalls on a load-use dependency, and also when a branch in decode needs a value that is not yet available. While stalled, it holds the program counter and the fetch/decode register and inserts a bubble into decode/execute. When a taken branch or jump redirects fetch, it clears the fetch/decode register, unless that same branch is still waiting for its operands.

The datapath multiplexers, the register file, the ALU and the memories sit outside this block.

Top module: `hazard_fwd_unit`

## Requirements
- R1: Each execute operand select (`e_fwd_a_o` for `e_rs_i`, `e_fwd_b_o` for `e_rt_i`) follows a fixed priority. It is 2'b10 (memory stage) when `m_we_i` is high and `m_rd_i` equals the source. Otherwise it is 2'b01 (writeback stage) when `w_we_i` is high and `w_rd_i` equals the source. Otherwise it is 2'b00 (register file). The code 2'b11 never appears.
- R2: Register number 0 never produces a forwarding match in any select, and never causes a stall.
- R3: A load in execute (`e_we_i` and `e_load_i` high) whose `e_rd_i` equals `d_rs_i` or `d_rt_i` raises the stall. This holds whether or not decode holds a branch.
- R4: A branch in decode (`d_branch_i` high) raises the stall when a non-load writer in execute targets either branch source.
- R5: A branch in decode raises the stall when a load in memory (`m_we_i` and `m_load_i` high) targets either branch source.
- R6: Each decode comparator select (`d_fwd_a_o` for `d_rs_i`, `d_fwd_b_o` for `d_rt_i`) follows a fixed priority. It is 2'b10 when a non-load writer in memory matches the source. Otherwise it is 2'b01 when the writeback writer matches (write-through). Otherwise it is 2'b00.
- R7: `flush_fd_o` is high exactly when `d_redirect_i` is high and no stall is raised.
- R8: `stall_pc_o`, `stall_fd_o` and `flush_de_o` always carry the same value, and that value is high only under the conditions of R3, R4 or R5.
- R9: A producer whose write enable is low never matches, even when its destination equals a source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| d_rs_i | input | 5 | first source register of the decode instruction |
| d_rt_i | input | 5 | second source register of the decode instruction |
| d_branch_i | input | 1 | decode instruction compares its sources for a branch or jump |
| d_redirect_i | input | 1 | decode branch resolved taken, fetch path is wrong |
| e_rs_i | input | 5 | first source register of the execute instruction |
| e_rt_i | input | 5 | second source register of the execute instruction |
| e_rd_i | input | 5 | destination register of the execute instruction |
| e_we_i | input | 1 | execute instruction writes a register |
| e_load_i | input | 1 | execute instruction is a load |
| m_rd_i | input | 5 | destination register of the memory-stage instruction |
| m_we_i | input | 1 | memory-stage instruction writes a register |
| m_load_i | input | 1 | memory-stage instruction is a load |
| w_rd_i | input | 5 | destination register of the writeback instruction |
| w_we_i | input | 1 | writeback instruction writes a register |
| e_fwd_a_o | output | 2 | select for execute operand A |
| e_fwd_b_o | output | 2 | select for execute operand B |
| d_fwd_a_o | output | 2 | select for decode comparator operand A |
| d_fwd_b_o | output | 2 | select for decode comparator operand B |
| stall_pc_o | output | 1 | hold the program counter |
| stall_fd_o | output | 1 | hold the fetch/decode register |
| flush_fd_o | output | 1 | clear the fetch/decode register |
| flush_de_o | output | 1 | insert a bubble into decode/execute |

## Verification
The assertions are immediate checks, and they are evaluated only once every input is a known value. They also assume that `d_redirect_i` is raised only together with `d_branch_i`, because a redirect comes only from a decode-stage branch. The stimulus drives every input with a defined value each cycle and raises redirect only on branch cycles. It draws register numbers from a narrow range that includes 0, so that same-register collisions across all three producer stages, and the zero-register case, occur often.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int unsigned REG_AW = 5;
  localparam int unsigned NSRC = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hzd_fwd_sel.sv
module hzd_fwd_sel
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW,
  parameter bit SKIP_MEM_LOAD = 1'b0   // decode path cannot take load data from memory
) (
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] m_rd_i,
  input  logic          m_we_i,
  input  logic          m_load_i,
  input  logic [AW-1:0] w_rd_i,
  input  logic          w_we_i,
  output logic [1:0]    sel_o
);
  logic src_live, m_hit, w_hit;
  fwd_sel_e sel;

  always_comb begin
    src_live = (src_i != '0);
    m_hit = src_live && m_we_i && (m_rd_i == src_i) && !(SKIP_MEM_LOAD && m_load_i);
    w_hit = src_live && w_we_i && (w_rd_i == src_i);
    if (m_hit)      sel = FWD_MEM;
    else if (w_hit) sel = FWD_WB;
    else            sel = FWD_RF;
    sel_o = sel;
  end

  always_comb begin
    if (!$isunknown({src_i, m_rd_i, m_we_i, m_load_i, w_rd_i, w_we_i})) begin
      assert_sel_legal_R1: assert (sel_o != 2'b11);
      assert_zero_src_rf_R2: assert (src_i != '0 || sel_o == 2'b00);
      assert_wb_needs_we_R9: assert (sel_o != 2'b01 || w_we_i);
      assert_mem_needs_we_R9: assert (sel_o != 2'b10 || m_we_i);
    end
  end
endmodule

// File: rtl/hzd_stall_ctl.sv
module hzd_stall_ctl
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [NSRC-1:0][AW-1:0] d_src_i,
  input  logic                    d_branch_i,
  input  logic [AW-1:0]           e_rd_i,
  input  logic                    e_we_i,
  input  logic                    e_load_i,
  input  logic [AW-1:0]           m_rd_i,
  input  logic                    m_we_i,
  input  logic                    m_load_i,
  output logic                    stall_o
);
  logic [NSRC-1:0] load_use, br_on_e, br_on_mload;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic live, e_match, m_match;
    assign live        = (d_src_i[g] != '0);
    assign e_match     = live && e_we_i && (e_rd_i == d_src_i[g]);
    assign m_match     = live && m_we_i && (m_rd_i == d_src_i[g]);
    assign load_use[g]    = e_match && e_load_i;
    assign br_on_e[g]     = e_match && d_branch_i && !e_load_i;
    assign br_on_mload[g] = m_match && d_branch_i && m_load_i;
  end

  assign stall_o = |{load_use, br_on_e, br_on_mload};

  always_comb begin
    if (!$isunknown({d_src_i, d_branch_i, e_rd_i, e_we_i, e_load_i, m_rd_i, m_we_i, m_load_i})) begin
      assert_zero_no_stall_R2: assert (!stall_o || d_src_i[0] != '0 || d_src_i[1] != '0);
      assert_idle_no_stall_R9: assert (!stall_o || e_we_i || m_we_i);
      assert_nonbranch_only_load_R3: assert (d_branch_i || !stall_o || (e_load_i && e_we_i));
    end
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzd_pkg::*;
#(
  parameter int unsigned AW = REG_AW
) (
  input  logic [AW-1:0] d_rs_i,
  input  logic [AW-1:0] d_rt_i,
  input  logic          d_branch_i,
  input  logic          d_redirect_i,
  input  logic [AW-1:0] e_rs_i,
  input  logic [AW-1:0] e_rt_i,
  input  logic [AW-1:0] e_rd_i,
  input  logic          e_we_i,
  input  logic          e_load_i,
  input  logic [AW-1:0] m_rd_i,
  input  logic          m_we_i,
  input  logic          m_load_i,
  input  logic [AW-1:0] w_rd_i,
  input  logic          w_we_i,
  output logic [1:0]    e_fwd_a_o,
  output logic [1:0]    e_fwd_b_o,
  output logic [1:0]    d_fwd_a_o,
  output logic [1:0]    d_fwd_b_o,
  output logic          stall_pc_o,
  output logic          stall_fd_o,
  output logic          flush_fd_o,
  output logic          flush_de_o
);
  logic [NSRC-1:0][AW-1:0] d_src, e_src;
  logic [NSRC-1:0][1:0]    d_sel, e_sel;
  logic                    stall;

  assign d_src = {d_rt_i, d_rs_i};
  assign e_src = {e_rt_i, e_rs_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_fwd
    hzd_fwd_sel #(.AW(AW), .SKIP_MEM_LOAD(1'b0)) u_e_sel (
      .src_i(e_src[g]), .m_rd_i(m_rd_i), .m_we_i(m_we_i), .m_load_i(m_load_i),
      .w_rd_i(w_rd_i), .w_we_i(w_we_i), .sel_o(e_sel[g])
    );
    hzd_fwd_sel #(.AW(AW), .SKIP_MEM_LOAD(1'b1)) u_d_sel (
      .src_i(d_src[g]), .m_rd_i(m_rd_i), .m_we_i(m_we_i), .m_load_i(m_load_i),
      .w_rd_i(w_rd_i), .w_we_i(w_we_i), .sel_o(d_sel[g])
    );
  end

  hzd_stall_ctl #(.AW(AW)) u_stall (
    .d_src_i(d_src), .d_branch_i(d_branch_i),
    .e_rd_i(e_rd_i), .e_we_i(e_we_i), .e_load_i(e_load_i),
    .m_rd_i(m_rd_i), .m_we_i(m_we_i), .m_load_i(m_load_i),
    .stall_o(stall)
  );

  assign e_fwd_a_o  = e_sel[0];
  assign e_fwd_b_o  = e_sel[1];
  assign d_fwd_a_o  = d_sel[0];
  assign d_fwd_b_o  = d_sel[1];
  assign stall_pc_o = stall;
  assign stall_fd_o = stall;
  assign flush_de_o = stall;    // bubble behind the held decode instruction
  // a branch still waiting on operands has not resolved yet: no flush
  assign flush_fd_o = d_redirect_i && !stall;

  always_comb begin
    if (!$isunknown({d_rs_i, d_rt_i, d_branch_i, d_redirect_i, e_rd_i, e_we_i, e_load_i,
                     m_rd_i, m_we_i, m_load_i, w_rd_i, w_we_i})) begin
      assert_redirect_is_branch_R7: assert (!d_redirect_i || d_branch_i);
      assert_flush_excl_stall_R7: assert (!(flush_fd_o && stall_pc_o));
      assert_stall_lockstep_R8: assert (stall_pc_o == stall_fd_o && stall_fd_o == flush_de_o);
      assert_dsel_no_mload_R6: assert (!(m_load_i && (d_fwd_a_o == 2'b10 || d_fwd_b_o == 2'b10)));
    end
  end
endmodule

// File: tb/hazard_fwd_unit_tb.sv
module hazard_fwd_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0] d_rs, d_rt, e_rs, e_rt, e_rd, m_rd, w_rd;
  logic d_br, d_redir, e_we, e_ld, m_we, m_ld, w_we;
  logic [1:0] efa, efb, dfa, dfb;
  logic spc, sfd, ffd, fde;

  int n_tests = 0;
  int n_fail = 0;
  int cyc = 0;

  hazard_fwd_unit u_dut (
    .d_rs_i(d_rs), .d_rt_i(d_rt), .d_branch_i(d_br), .d_redirect_i(d_redir),
    .e_rs_i(e_rs), .e_rt_i(e_rt), .e_rd_i(e_rd), .e_we_i(e_we), .e_load_i(e_ld),
    .m_rd_i(m_rd), .m_we_i(m_we), .m_load_i(m_ld), .w_rd_i(w_rd), .w_we_i(w_we),
    .e_fwd_a_o(efa), .e_fwd_b_o(efb), .d_fwd_a_o(dfa), .d_fwd_b_o(dfb),
    .stall_pc_o(spc), .stall_fd_o(sfd), .flush_fd_o(ffd), .flush_de_o(fde)
  );

  // behavioural reference
  function automatic int ref_e(int s);
    if (s != 0 && m_we && int'(m_rd) == s) return 2;
    if (s != 0 && w_we && int'(w_rd) == s) return 1;
    return 0;
  endfunction

  function automatic int ref_d(int s);
    if (s != 0 && m_we && !m_ld && int'(m_rd) == s) return 2;
    if (s != 0 && w_we && int'(w_rd) == s) return 1;
    return 0;
  endfunction

  function automatic bit ref_stall(output string why);
    int srcs[2];
    why = "R8";
    srcs[0] = d_rs; srcs[1] = d_rt;
    foreach (srcs[k]) begin
      if (srcs[k] == 0) continue;
      if (e_we && e_ld && int'(e_rd) == srcs[k]) begin why = "R3"; return 1; end
      if (d_br && e_we && !e_ld && int'(e_rd) == srcs[k]) begin why = "R4"; return 1; end
      if (d_br && m_we && m_ld && int'(m_rd) == srcs[k]) begin why = "R5"; return 1; end
    end
    return 0;
  endfunction

  task automatic chk(string tag, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d got=%0d exp=%0d", tag, cyc, got, exp);
    end
  endtask

  task automatic compare_all(string tag_hint);
    string why;
    bit st;
    st = ref_stall(why);
    chk({tag_hint, " R1 e_fwd_a"}, int'(efa), ref_e(int'(e_rs)));
    chk({tag_hint, " R1 e_fwd_b"}, int'(efb), ref_e(int'(e_rt)));
    chk({tag_hint, " R6 d_fwd_a"}, int'(dfa), ref_d(int'(d_rs)));
    chk({tag_hint, " R6 d_fwd_b"}, int'(dfb), ref_d(int'(d_rt)));
    chk({tag_hint, " ", why, " stall_pc"}, int'(spc), int'(st));
    chk({tag_hint, " R8 stall_fd"}, int'(sfd), int'(st));
    chk({tag_hint, " R8 flush_de"}, int'(fde), int'(st));
    chk({tag_hint, " R7 flush_fd"}, int'(ffd), int'(d_redir && !st));
  endtask

  task automatic idle();
    {d_rs, d_rt, e_rs, e_rt, e_rd, m_rd, w_rd} = '0;
    {d_br, d_redir, e_we, e_ld, m_we, m_ld, w_we} = '0;
  endtask

  // drive after posedge, check at negedge
  task automatic step(string tag);
    @(negedge clk);
    cyc++;
    compare_all(tag);
    @(posedge clk);
    #1;
  endtask

  initial begin
    idle();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    step("reset-idle");

    // R1 priority: memory beats writeback on same register
    idle(); e_rs = 3; e_rt = 4; m_we = 1; m_rd = 3; w_we = 1; w_rd = 3;
    step("R1 mem-over-wb");
    chk("R1 directed", int'(efa), 2);
    idle(); e_rt = 4; w_we = 1; w_rd = 4;
    step("R1 wb-only");
    chk("R1 directed wb", int'(efb), 1);

    // R2 register 0
    idle(); e_rs = 0; d_rs = 0; d_br = 1; e_we = 1; e_ld = 1; e_rd = 0; m_we = 1; m_rd = 0;
    w_we = 1; w_rd = 0;
    step("R2 zero");
    chk("R2 no stall", int'(spc), 0);
    chk("R2 no fwd", int'(efa), 0);

    // R3 load-use on non-branch
    idle(); d_rt = 7; e_we = 1; e_ld = 1; e_rd = 7;
    step("R3 load-use");
    chk("R3 directed", int'(spc), 1);

    // R4 branch on ALU result in execute, then R6 from memory next cycle
    idle(); d_br = 1; d_redir = 1; d_rs = 5; e_we = 1; e_rd = 5;
    step("R4 br-alu");
    chk("R4 directed", int'(spc), 1);
    chk("R7 no flush while stalled", int'(ffd), 0);
    idle(); d_br = 1; d_redir = 1; d_rs = 5; m_we = 1; m_rd = 5;
    step("R6 br-from-mem");
    chk("R6 directed", int'(dfa), 2);
    chk("R7 flush once resolved", int'(ffd), 1);

    // R5 branch on load in memory; R6 no mem forward of load data
    idle(); d_br = 1; d_rt = 9; m_we = 1; m_ld = 1; m_rd = 9; w_we = 1; w_rd = 9;
    step("R5 br-mload");
    chk("R5 directed", int'(spc), 1);
    chk("R6 load not from mem", int'(dfb), 1);

    // R9 write enables low
    idle(); d_br = 1; d_rs = 6; e_rs = 6; e_rd = 6; e_ld = 1; m_rd = 6; w_rd = 6;
    step("R9 we-low");
    chk("R9 no stall", int'(spc), 0);
    chk("R9 no efwd", int'(efa), 0);
    chk("R9 no dfwd", int'(dfa), 0);

    // constrained random: narrow register range for frequent collisions
    for (int i = 0; i < 4000; i++) begin
      d_rs = 5'($urandom_range(0, 3)); d_rt = 5'($urandom_range(0, 3));
      e_rs = 5'($urandom_range(0, 3)); e_rt = 5'($urandom_range(0, 3));
      e_rd = 5'($urandom_range(0, 3)); m_rd = 5'($urandom_range(0, 3));
      w_rd = 5'($urandom_range(0, 3));
      d_br = 1'($urandom); d_redir = d_br & 1'($urandom);
      e_we = 1'($urandom); e_ld = e_we & 1'($urandom);
      m_we = 1'($urandom); m_ld = m_we & 1'($urandom);
      w_we = 1'($urandom);
      step("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule